// File: doc/BRIEF.md
# Embedded Core Test Wrapper

This block sits between a host chip and an embedded core so that the core and the wiring around it can be tested through a serial test port. Every core input terminal and every core output terminal gets its own wrapper cell. Each cell has a capture/shift flip-flop and a separate update latch. The cells form one serial path. A small controller holds a 2-bit mode instruction that is shifted in through the same port. Control inputs decide whether the instruction register or the data path is accessed, and whether that path captures, shifts or updates on a rising test clock edge.

The wrapper has four modes. In functional mode the core and the host connect straight through. In external-test mode the output-side cells drive the host wires, which exercises the interconnect, and the input-side cells observe what arrives from the host. In internal-test mode the input-side cells drive the core inputs and the output-side cells capture the core's response. In bypass mode the core runs normally and the serial path shrinks to a single flip-flop.

Top module: `core_wrap`

## Requirements
- R1: A synchronous active-high reset `rst` returns the instruction to functional mode (code 00) and clears every update latch and scan flip-flop. After reset, `core_in` equals `host_in` and `host_out` equals `core_out`.
- R2: In functional mode (00), `core_in` follows `host_in` and `host_out` follows `core_out` combinationally.
- R3: With `select_ir` high, `shift` moves the instruction shift register one place toward bit 0, with `wsi` entering at bit 1, so the first bit shifted in is bit 0. `update` then copies it into the active instruction. The codes are 00 functional, 01 external test, 10 internal test and 11 bypass.
- R4: With `select_ir` low and a mode other than bypass, each `shift` edge moves the data path one place. Data enters at `wsi`, runs through input cells 0 to N_IN-1 and then output cells 0 to N_OUT-1, and `wso` shows the last output cell.
- R5: A data-path `capture` loads each input cell from its `host_in` bit and each output cell from its `core_out` bit.
- R6: When `capture` and `shift` are both high, the cells capture and do not shift.
- R7: In external-test mode (01), `host_out` is driven from the output cells' update latches, while `core_in` still follows `host_in`.
- R8: In internal-test mode (10), `core_in` is driven from the input cells' update latches, while `host_out` follows `core_out`.
- R9: Driven values change only on a data-path `update` edge. Shifting and capturing leave `core_in` and `host_out` unchanged.
- R10: In bypass mode (11), the core connects straight through. The data path is a single flip-flop: `shift` loads it from `wsi`, `capture` clears it, and `wso` shows it.
- R11: With `select_ir` high, `capture` loads the active instruction into the instruction shift register, so the instruction can be read back LSB first on `wso`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock, rising edge active |
| rst | input | 1 | Synchronous active-high test reset |
| wsi | input | 1 | Serial test data in |
| select_ir | input | 1 | 1 selects the instruction register, 0 the data path |
| capture | input | 1 | Capture enable |
| shift | input | 1 | Shift enable |
| update | input | 1 | Update enable |
| wso | output | 1 | Serial test data out |
| host_in | input | N_IN | Host-side signals toward the core |
| core_in | output | N_IN | Drives the core input terminals |
| core_out | input | N_OUT | Core output terminals |
| host_out | output | N_OUT | Drives the host-side wires |

## Verification
The hardest state to reach from the ports is internal test with a stimulus that differs from both the reset value and the host value. Getting there takes several steps: load an instruction, capture, shift a full vector, update, then capture again to read the core's response. The bench reaches it with a core stub that inverts selected bits, so each captured response can be told apart from the stimulus. It loads the input latches in one mode, switches to internal test, and checks that the captured output cells show the stub's function of the latched stimulus. Holding during a partial shift and resetting while in internal test are exercised along the same path.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
  localparam int IR_W = 2;

  typedef enum logic [IR_W-1:0] {
    MODE_FUNC = 2'b00,
    MODE_EXT  = 2'b01,
    MODE_INT  = 2'b10,
    MODE_BYP  = 2'b11
  } wmode_e;
endpackage

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
  import wrap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wsi,
  input  logic            select_ir,
  input  logic            capture,
  input  logic            shift,
  input  logic            update,
  output wmode_e          instr,
  output logic [IR_W-1:0] ir_sh,
  output logic            byp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ir_sh <= '0;
      instr <= MODE_FUNC;
      byp_q <= 1'b0;
    end else if (select_ir) begin
      if (capture)
        ir_sh <= instr;
      else if (shift)
        ir_sh <= {wsi, ir_sh[IR_W-1:1]};
      if (update)
        instr <= wmode_e'(ir_sh);
    end else if (instr == MODE_BYP) begin
      if (capture)
        byp_q <= 1'b0;
      else if (shift)
        byp_q <= wsi;
    end
  end
endmodule

// File: rtl/wrap_cell.sv
module wrap_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic si,
  output logic q,
  output logic upd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      if (cap_en)
        q <= cap_d;
      else if (shift_en)
        q <= si;
      if (upd_en)
        upd_q <= q;
    end
  end
endmodule

// File: rtl/core_wrap.sv
module core_wrap
  import wrap_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wsi,
  input  logic             select_ir,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  output logic             wso,
  input  logic [N_IN-1:0]  host_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] host_out
);
  localparam int N = N_IN + N_OUT;

  wmode_e          instr;
  logic [IR_W-1:0] ir_sh;
  logic            byp_q;
  logic [N-1:0]    cell_q;
  logic [N-1:0]    cell_upd;
  logic            dr_act;

  wrap_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wsi       (wsi),
    .select_ir (select_ir),
    .capture   (capture),
    .shift     (shift),
    .update    (update),
    .instr     (instr),
    .ir_sh     (ir_sh),
    .byp_q     (byp_q)
  );

  assign dr_act = !select_ir && (instr != MODE_BYP);

  for (genvar k = 0; k < N; k++) begin : g_cell
    logic si_k;
    logic cap_k;
    if (k == 0) begin : g_first
      assign si_k = wsi;
    end else begin : g_next
      assign si_k = cell_q[k-1];
    end
    if (k < N_IN) begin : g_in
      assign cap_k = host_in[k];
    end else begin : g_out
      assign cap_k = core_out[k-N_IN];
    end
    wrap_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .cap_en   (dr_act && capture),
      .shift_en (dr_act && shift),
      .upd_en   (dr_act && update),
      .cap_d    (cap_k),
      .si       (si_k),
      .q        (cell_q[k]),
      .upd_q    (cell_upd[k])
    );
  end

  always_comb begin
    core_in  = (instr == MODE_INT) ? cell_upd[N_IN-1:0] : host_in;
    host_out = (instr == MODE_EXT) ? cell_upd[N-1:N_IN] : core_out;
    if (select_ir)
      wso = ir_sh[0];
    else if (instr == MODE_BYP)
      wso = byp_q;
    else
      wso = cell_q[N-1];
  end
endmodule

// File: rtl/wrap_chk.sv
module wrap_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wsi,
  input logic         select_ir,
  input logic         capture,
  input logic         shift,
  input logic         update,
  input logic         host_in0,
  input logic [1:0]   instr,
  input logic [1:0]   ir_sh,
  input logic         byp_q,
  input logic         cell_q0,
  input logic [N-1:0] cell_upd
);
  logic data_sel;
  assign data_sel = !select_ir && (instr != 2'b11);

  assert_reset_func_R1: assert property (@(posedge clk)
    rst |=> (instr == 2'b00 && cell_upd == '0));

  assert_ir_update_R3: assert property (@(posedge clk) disable iff (rst)
    (select_ir && update) |=> (instr == $past(ir_sh)));

  assert_shift_in_R4: assert property (@(posedge clk) disable iff (rst)
    (data_sel && shift && !capture) |=> (cell_q0 == $past(wsi)));

  assert_cap_prio_R6: assert property (@(posedge clk) disable iff (rst)
    (data_sel && capture && shift) |=> (cell_q0 == $past(host_in0)));

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(data_sel && update) |=> $stable(cell_upd));

  assert_bypass_shift_R10: assert property (@(posedge clk) disable iff (rst)
    (!select_ir && instr == 2'b11 && shift && !capture) |=> (byp_q == $past(wsi)));
endmodule

bind core_wrap wrap_chk #(.N(N_IN + N_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wsi       (wsi),
  .select_ir (select_ir),
  .capture   (capture),
  .shift     (shift),
  .update    (update),
  .host_in0  (host_in[0]),
  .instr     (instr),
  .ir_sh     (ir_sh),
  .byp_q     (byp_q),
  .cell_q0   (cell_q[0]),
  .cell_upd  (cell_upd)
);

// File: tb/sim_core_wrap.sv
`timescale 1ns/1ps
module sim_core_wrap;
  localparam int NI = 4;
  localparam int NO = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wsi = 1'b0, select_ir = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0;
  logic wso;
  logic [NI-1:0] host_in = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out;
  logic [NO-1:0] host_out;

  always #10 clk = ~clk;

  assign core_out = core_in ^ 4'hA;

  core_wrap #(.N_IN(NI), .N_OUT(NO)) u0 (
    .clk(clk), .rst(rst), .wsi(wsi), .select_ir(select_ir),
    .capture(capture), .shift(shift), .update(update), .wso(wso),
    .host_in(host_in), .core_in(core_in), .core_out(core_out), .host_out(host_out)
  );

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {7'b0, wso};
        1: act = {4'b0, core_in};
        default: act = {4'b0, host_out};
      endcase
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic drv(input logic s, input logic c, input logic sh, input logic u, input logic si);
    select_ir = s; capture = c; shift = sh; update = u; wsi = si;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic expect_v(input int k, input logic [7:0] e, input string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic ld_ir(input logic [1:0] v);
    drv(1, 0, 1, 0, v[0]); step();
    drv(1, 0, 1, 0, v[1]); step();
    drv(1, 0, 0, 1, 0);    step();
    drv(0, 0, 0, 0, 0);
  endtask

  task automatic dr_capture();
    drv(0, 1, 0, 0, 0); step();
    drv(0, 0, 0, 0, 0);
  endtask

  task automatic dr_update();
    drv(0, 0, 0, 1, 0); step();
    drv(0, 0, 0, 0, 0);
  endtask

  task automatic dr_scan(input logic [7:0] v, input logic [7:0] cap, input string r);
    for (int s = 0; s < 8; s++) begin
      drv(0, 0, 1, 0, v[7-s]);
      expect_v(0, {7'b0, cap[7-s]}, r);
      step();
    end
    drv(0, 0, 0, 0, 0);
  endtask

  initial begin
    host_in = 4'h5;
    step(); step(); step();
    expect_v(1, 8'h05, "R1");
    expect_v(2, 8'h0F, "R1");
    rst = 1'b0;
    step();

    host_in = 4'h3;
    expect_v(1, 8'h03, "R2");
    expect_v(2, 8'h09, "R2");
    step();

    ld_ir(2'b01);
    drv(1, 1, 0, 0, 0); step();
    drv(1, 0, 1, 0, 0);
    expect_v(0, 8'h01, "R11");
    step();
    expect_v(0, 8'h00, "R11");
    step();
    drv(0, 0, 0, 0, 0);

    host_in = 4'h6;
    expect_v(2, 8'h00, "R7");
    expect_v(1, 8'h06, "R7");
    step();

    host_in = 4'h2;
    drv(0, 1, 1, 0, 1); step();
    drv(0, 0, 0, 0, 0);
    dr_scan(8'h90, 8'h82, "R6");
    expect_v(2, 8'h00, "R9");
    step();
    dr_update();
    expect_v(2, 8'h09, "R7");
    expect_v(1, 8'h02, "R7");
    step();

    host_in = 4'h6;
    dr_capture();
    dr_scan(8'h07, 8'hC6, "R5");

    host_in = 4'hF;
    ld_ir(2'b10);
    expect_v(1, 8'h00, "R8");
    expect_v(2, 8'h0A, "R8");
    step();
    dr_capture();
    dr_scan(8'h07, 8'hAF, "R4");
    dr_update();
    expect_v(1, 8'h07, "R8");
    expect_v(2, 8'h0D, "R8");
    step();

    drv(0, 0, 1, 0, 1); step(); step(); step();
    expect_v(1, 8'h07, "R9");
    step();
    drv(0, 1, 0, 0, 0);
    expect_v(1, 8'h07, "R9");
    step();
    drv(0, 0, 0, 0, 0);
    dr_scan(8'h00, 8'hDF, "R8");

    rst = 1'b1; step();
    rst = 1'b0;
    expect_v(1, 8'h0F, "R1");
    expect_v(2, 8'h05, "R1");
    step();

    ld_ir(2'b11);
    host_in = 4'h1;
    expect_v(1, 8'h01, "R10");
    expect_v(2, 8'h0B, "R10");
    step();
    drv(0, 0, 1, 0, 1); step();
    drv(0, 1, 0, 0, 0);
    expect_v(0, 8'h01, "R10");
    step();
    drv(0, 0, 0, 0, 0);
    expect_v(0, 8'h00, "R10");
    step();

    ld_ir(2'b00);
    host_in = 4'h4;
    expect_v(1, 8'h04, "R2");
    expect_v(2, 8'h0E, "R2");
    step();

    @(negedge clk); @(negedge clk); #1;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule